// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the processor-facing side of an SPI master. It decodes 32-bit, word-aligned reads and writes on a simple select/write bus. It keeps the configuration that the serial engine uses: control word, auxiliary control, enable, slave select, clock divider, the two FIFO thresholds and the receive sample delay. It also holds a transmit FIFO and a receive FIFO, which share one data register.

Software fills the transmit FIFO by writing the data register and empties the receive FIFO by reading it. The shift engine, which is outside this block, pops transmit words and pushes receive words through dedicated ports. The clock and frame configuration can be changed only while the controller is off. The FIFO depth is a build parameter. Software finds it by writing increasing values to a threshold register and reading each one back: any value that does not fit in the FIFO is refused.

Top module: `spim_regif`

## Requirements
- R1: After reset every register reads zero, both FIFO levels are zero and the status register reads 0x06 (transmit not full, transmit empty) while the engine is idle.
- R2: A write to the data register (0x60) pushes bits 15:0 into the transmit FIFO. The engine sees the oldest entry on `eng_tx_data`, `eng_tx_pop` removes it, and the TX level register (0x20) and `tx_level` give the entry count.
- R3: A data write while the transmit FIFO holds DEPTH entries is dropped. It raises `tx_ovf_pulse` in the cycle of the write, and the level stays at DEPTH.
- R4: `eng_rx_push` stores `eng_rx_data` when the receive FIFO is not full. A data register read returns the oldest entry in bits 15:0 and removes it. The RX level register (0x24) gives the count, and a push offered while the FIFO is full is dropped.
- R5: A data register read while the receive FIFO is empty returns zero and raises `rx_unf_pulse` in the cycle of the read.
- R6: The control word (0x00) keeps bits 11:0, which are frame size 3:0, frame format 5:4, clock phase 6, clock polarity 7, transfer mode 9:8, slave output disable 10 and loopback 11. It drives `cfg_ctrl0` with these bits, and its upper bits read zero.
- R7: Writes to the control word (0x00), auxiliary control (0x04, 16 bits), slave select (0x10, NUM_SS bits) and divider (0x14, 16 bits) take effect only while the enable bit is 0. Otherwise they leave the register unchanged.
- R8: Writing 0 to enable bit 0 (0x08) while it is 1 empties both FIFOs, and both levels read zero in the next cycle. An engine push offered in that same cycle is discarded.
- R9: The TX threshold (0x18) and RX threshold (0x1C) take a written value only if it is below DEPTH. Otherwise they keep their previous value.
- R10: Status (0x28) bit 0 is `eng_busy`, bit 1 is transmit not full, bit 2 is transmit empty, bit 3 is receive not empty and bit 4 is receive full.
- R11: Reads of an offset outside the register map return zero.
- R12: The sample delay register (0xFC) keeps bits 7:0 of a write at any time, including while the enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tx_ovf_pulse | output | 1 | Data write to a full transmit FIFO |
| rx_unf_pulse | output | 1 | Data read from an empty receive FIFO |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 16 | Transmit FIFO head |
| eng_tx_empty | output | 1 | Transmit FIFO empty |
| eng_rx_push | input | 1 | Engine delivers a received frame |
| eng_rx_data | input | 16 | Received frame |
| eng_busy | input | 1 | Engine is shifting |
| cfg_enable | output | 1 | Controller enable |
| cfg_ctrl0 | output | 12 | Control word fields |
| cfg_ctrl1 | output | 16 | Auxiliary control |
| cfg_slv_sel | output | NUM_SS | Slave select bits |
| cfg_divider | output | 16 | Serial clock divider |
| cfg_tx_thresh | output | clog2(DEPTH) | Transmit threshold |
| cfg_rx_thresh | output | clog2(DEPTH) | Receive threshold |
| cfg_sample_dly | output | 8 | Receive sample delay |
| tx_level | output | clog2(DEPTH+1) | Transmit entry count |
| rx_level | output | clog2(DEPTH+1) | Receive entry count |

## Verification
The bench builds the block with DEPTH = 6 and NUM_SS = 4. With a depth that is not a power of two, both FIFO pointers must wrap early. The threshold fields are three bits wide, so they could hold 6 and 7, and the bench writes those values to show that the depth check refuses them where a width check alone would not. The bench fills both FIFOs in a few cycles to reach overflow, dropped pushes and the full status bit. It also offers a flush together with an engine push, and it pops and pushes in the same cycle on a full FIFO.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] OFS_CTRL0   = 8'h00;
  localparam logic [7:0] OFS_CTRL1   = 8'h04;
  localparam logic [7:0] OFS_ENABLE  = 8'h08;
  localparam logic [7:0] OFS_SLVSEL  = 8'h10;
  localparam logic [7:0] OFS_DIVIDER = 8'h14;
  localparam logic [7:0] OFS_TXTH    = 8'h18;
  localparam logic [7:0] OFS_RXTH    = 8'h1C;
  localparam logic [7:0] OFS_TXLVL   = 8'h20;
  localparam logic [7:0] OFS_RXLVL   = 8'h24;
  localparam logic [7:0] OFS_STATUS  = 8'h28;
  localparam logic [7:0] OFS_DATA    = 8'h60;
  localparam logic [7:0] OFS_SMPDLY  = 8'hFC;

  localparam int ST_BUSY      = 0;
  localparam int ST_TX_NFULL  = 1;
  localparam int ST_TX_EMPTY  = 2;
  localparam int ST_RX_NEMPTY = 3;
  localparam int ST_RX_FULL   = 4;
  localparam int ST_W         = 5;

  localparam int CTRL0_W = 12;
  localparam int FRAME_W = 16;

  // A threshold is kept only when it names a level the FIFO can reach below full.
  function automatic logic thresh_fits(input logic [31:0] v, input int unsigned depth);
    return v < depth;
  endfunction

  function automatic logic [7:0] word_addr(input logic [7:0] a);
    return {a[7:2], 2'b00};
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             push_ok, pop_ok;

  assign full    = (count == LVL_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      count <= count + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= wdata;
  end
endmodule

// File: rtl/spim_cfg_bank.sv
module spim_cfg_bank
  import spim_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NUM_SS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [7:0]                 addr,
  input  logic [31:0]                wdata,
  output logic                       en,
  output logic [CTRL0_W-1:0]         ctrl0,
  output logic [15:0]                ctrl1,
  output logic [NUM_SS-1:0]          slv,
  output logic [15:0]                div,
  output logic [$clog2(DEPTH)-1:0]   txth,
  output logic [$clog2(DEPTH)-1:0]   rxth,
  output logic [7:0]                 dly,
  output logic                       flush_ev,
  output logic                       locked_wr_ev
);
  localparam int TH_W = $clog2(DEPTH);

  logic hit_ctrl0, hit_ctrl1, hit_en, hit_slv, hit_div, hit_txth, hit_rxth, hit_dly;
  logic grp_hit, grp_open;

  assign hit_ctrl0 = wr_stb && addr == OFS_CTRL0;
  assign hit_ctrl1 = wr_stb && addr == OFS_CTRL1;
  assign hit_en    = wr_stb && addr == OFS_ENABLE;
  assign hit_slv   = wr_stb && addr == OFS_SLVSEL;
  assign hit_div   = wr_stb && addr == OFS_DIVIDER;
  assign hit_txth  = wr_stb && addr == OFS_TXTH;
  assign hit_rxth  = wr_stb && addr == OFS_RXTH;
  assign hit_dly   = wr_stb && addr == OFS_SMPDLY;

  assign grp_hit      = hit_ctrl0 | hit_ctrl1 | hit_slv | hit_div;
  assign grp_open     = ~en;
  assign locked_wr_ev = grp_hit & en;
  assign flush_ev     = hit_en & en & ~wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      ctrl0 <= '0;
      ctrl1 <= '0;
      slv   <= '0;
      div   <= '0;
      txth  <= '0;
      rxth  <= '0;
      dly   <= '0;
    end else begin
      if (hit_en) en <= wdata[0];
      if (grp_open) begin
        if (hit_ctrl0) ctrl0 <= wdata[CTRL0_W-1:0];
        if (hit_ctrl1) ctrl1 <= wdata[15:0];
        if (hit_slv)   slv   <= wdata[NUM_SS-1:0];
        if (hit_div)   div   <= wdata[15:0];
      end
      if (hit_txth && thresh_fits(wdata, DEPTH)) txth <= wdata[TH_W-1:0];
      if (hit_rxth && thresh_fits(wdata, DEPTH)) rxth <= wdata[TH_W-1:0];
      if (hit_dly) dly <= wdata[7:0];
    end
  end
endmodule

// File: rtl/spim_regif.sv
module spim_regif
  import spim_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NUM_SS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [7:0]                   bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         tx_ovf_pulse,
  output logic                         rx_unf_pulse,
  input  logic                         eng_tx_pop,
  output logic [15:0]                  eng_tx_data,
  output logic                         eng_tx_empty,
  input  logic                         eng_rx_push,
  input  logic [15:0]                  eng_rx_data,
  input  logic                         eng_busy,
  output logic                         cfg_enable,
  output logic [11:0]                  cfg_ctrl0,
  output logic [15:0]                  cfg_ctrl1,
  output logic [NUM_SS-1:0]            cfg_slv_sel,
  output logic [15:0]                  cfg_divider,
  output logic [$clog2(DEPTH)-1:0]     cfg_tx_thresh,
  output logic [$clog2(DEPTH)-1:0]     cfg_rx_thresh,
  output logic [7:0]                   cfg_sample_dly,
  output logic [$clog2(DEPTH+1)-1:0]   tx_level,
  output logic [$clog2(DEPTH+1)-1:0]   rx_level
);
  logic [7:0]       waddr;
  logic             wr_stb, rd_stb;
  logic             data_wr_ev, data_rd_ev;
  logic             flush_ev, locked_wr_ev;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [15:0]      rx_head;
  logic [ST_W-1:0]  status;

  assign waddr      = word_addr(bus_addr);
  assign wr_stb     = bus_sel & bus_wr;
  assign rd_stb     = bus_sel & ~bus_wr;
  assign data_wr_ev = wr_stb && waddr == OFS_DATA;
  assign data_rd_ev = rd_stb && waddr == OFS_DATA;

  assign tx_ovf_pulse = data_wr_ev & tx_full;
  assign rx_unf_pulse = data_rd_ev & rx_empty;
  assign eng_tx_empty = tx_empty;

  spim_cfg_bank #(.DEPTH(DEPTH), .NUM_SS(NUM_SS)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (wr_stb),
    .addr         (waddr),
    .wdata        (bus_wdata),
    .en           (cfg_enable),
    .ctrl0        (cfg_ctrl0),
    .ctrl1        (cfg_ctrl1),
    .slv          (cfg_slv_sel),
    .div          (cfg_divider),
    .txth         (cfg_tx_thresh),
    .rxth         (cfg_rx_thresh),
    .dly          (cfg_sample_dly),
    .flush_ev     (flush_ev),
    .locked_wr_ev (locked_wr_ev)
  );

  spim_fifo #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush_ev),
    .push  (data_wr_ev),
    .wdata (bus_wdata[FRAME_W-1:0]),
    .pop   (eng_tx_pop),
    .head  (eng_tx_data),
    .count (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  spim_fifo #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush_ev),
    .push  (eng_rx_push),
    .wdata (eng_rx_data),
    .pop   (data_rd_ev),
    .head  (rx_head),
    .count (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  always_comb begin
    status               = '0;
    status[ST_BUSY]      = eng_busy;
    status[ST_TX_NFULL]  = ~tx_full;
    status[ST_TX_EMPTY]  = tx_empty;
    status[ST_RX_NEMPTY] = ~rx_empty;
    status[ST_RX_FULL]   = rx_full;
  end

  always_comb begin
    case (waddr)
      OFS_CTRL0:   bus_rdata = 32'(cfg_ctrl0);
      OFS_CTRL1:   bus_rdata = 32'(cfg_ctrl1);
      OFS_ENABLE:  bus_rdata = 32'(cfg_enable);
      OFS_SLVSEL:  bus_rdata = 32'(cfg_slv_sel);
      OFS_DIVIDER: bus_rdata = 32'(cfg_divider);
      OFS_TXTH:    bus_rdata = 32'(cfg_tx_thresh);
      OFS_RXTH:    bus_rdata = 32'(cfg_rx_thresh);
      OFS_TXLVL:   bus_rdata = 32'(tx_level);
      OFS_RXLVL:   bus_rdata = 32'(rx_level);
      OFS_STATUS:  bus_rdata = 32'(status);
      OFS_DATA:    bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      OFS_SMPDLY:  bus_rdata = 32'(cfg_sample_dly);
      default:     bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/spim_regif_chk.sv
module spim_regif_chk #(
  parameter int DEPTH  = 8,
  parameter int NUM_SS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         flush_ev,
  input logic                         locked_wr_ev,
  input logic                         cfg_enable,
  input logic [11:0]                  cfg_ctrl0,
  input logic [15:0]                  cfg_ctrl1,
  input logic [NUM_SS-1:0]            cfg_slv_sel,
  input logic [15:0]                  cfg_divider,
  input logic [$clog2(DEPTH)-1:0]     cfg_tx_thresh,
  input logic [$clog2(DEPTH)-1:0]     cfg_rx_thresh,
  input logic                         tx_ovf_pulse,
  input logic                         rx_unf_pulse,
  input logic [31:0]                  bus_rdata,
  input logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input logic [$clog2(DEPTH+1)-1:0]   rx_level
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int TH_W  = $clog2(DEPTH);

  a_r3_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_pulse |-> tx_level == LVL_W'(DEPTH));

  a_r5_unf_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf_pulse |-> (bus_rdata == 32'd0 && rx_level == '0));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ev |=> (tx_level == '0 && rx_level == '0 && !cfg_enable));

  a_r7_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    locked_wr_ev |=> ($stable(cfg_ctrl0) && $stable(cfg_ctrl1) &&
                      $stable(cfg_slv_sel) && $stable(cfg_divider)));

  a_r9_thresh_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cfg_tx_thresh} < (TH_W+1)'(DEPTH)) && ({1'b0, cfg_rx_thresh} < (TH_W+1)'(DEPTH)));

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));
endmodule

bind spim_regif spim_regif_chk #(.DEPTH(DEPTH), .NUM_SS(NUM_SS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_ev      (flush_ev),
  .locked_wr_ev  (locked_wr_ev),
  .cfg_enable    (cfg_enable),
  .cfg_ctrl0     (cfg_ctrl0),
  .cfg_ctrl1     (cfg_ctrl1),
  .cfg_slv_sel   (cfg_slv_sel),
  .cfg_divider   (cfg_divider),
  .cfg_tx_thresh (cfg_tx_thresh),
  .cfg_rx_thresh (cfg_rx_thresh),
  .tx_ovf_pulse  (tx_ovf_pulse),
  .rx_unf_pulse  (rx_unf_pulse),
  .bus_rdata     (bus_rdata),
  .tx_level      (tx_level),
  .rx_level      (rx_level)
);

// File: tb/spim_regif_test.sv
module spim_regif_test;
  localparam int DEPTH  = 6;
  localparam int NUM_SS = 4;
  localparam int TH_W   = $clog2(DEPTH);
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tx_ovf_pulse, rx_unf_pulse;
  logic eng_tx_pop = 0, eng_rx_push = 0, eng_busy = 0;
  logic [15:0] eng_rx_data = '0;
  logic [15:0] eng_tx_data;
  logic eng_tx_empty, cfg_enable;
  logic [11:0] cfg_ctrl0;
  logic [15:0] cfg_ctrl1, cfg_divider;
  logic [NUM_SS-1:0] cfg_slv_sel;
  logic [TH_W-1:0] cfg_tx_thresh, cfg_rx_thresh;
  logic [7:0] cfg_sample_dly;
  logic [LVL_W-1:0] tx_level, rx_level;

  always #10 clk = ~clk;

  spim_regif #(.DEPTH(DEPTH), .NUM_SS(NUM_SS)) uut (.*);

  // reference state
  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  bit          m_en;
  logic [11:0] m_ctrl0;
  logic [15:0] m_ctrl1, m_div;
  logic [NUM_SS-1:0] m_slv;
  int unsigned m_txth, m_rxth;
  logic [7:0]  m_dly;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r;
    case ({a[7:2], 2'b00})
      8'h00: r = 32'(m_ctrl0);
      8'h04: r = 32'(m_ctrl1);
      8'h08: r = 32'(m_en);
      8'h10: r = 32'(m_slv);
      8'h14: r = 32'(m_div);
      8'h18: r = m_txth;
      8'h1C: r = m_rxth;
      8'h20: r = txq.size();
      8'h24: r = rxq.size();
      8'h28: r = {27'd0, rxq.size() == DEPTH, rxq.size() != 0, txq.size() == 0,
                  txq.size() != DEPTH, eng_busy};
      8'h60: r = (rxq.size() != 0) ? 32'(rxq[0]) : 32'd0;
      8'hFC: r = 32'(m_dly);
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  task automatic chk_state(input string tag);
    chk(32'(cfg_enable), 32'(m_en), tag, "enable");
    chk(32'(cfg_ctrl0), 32'(m_ctrl0), tag, "ctrl0");
    chk(32'(cfg_ctrl1), 32'(m_ctrl1), tag, "ctrl1");
    chk(32'(cfg_slv_sel), 32'(m_slv), tag, "slave");
    chk(32'(cfg_divider), 32'(m_div), tag, "divider");
    chk(32'(cfg_tx_thresh), m_txth, tag, "tx_thresh");
    chk(32'(cfg_rx_thresh), m_rxth, tag, "rx_thresh");
    chk(32'(cfg_sample_dly), 32'(m_dly), tag, "sample_dly");
    chk(32'(tx_level), txq.size(), tag, "tx_level");
    chk(32'(rx_level), rxq.size(), tag, "rx_level");
    chk(32'(eng_tx_empty), 32'(txq.size() == 0), tag, "tx_empty");
    if (txq.size() != 0) chk(32'(eng_tx_data), 32'(txq[0]), tag, "tx_head");
  endtask

  task automatic step(input bit sel, input bit wr, input logic [7:0] a, input logic [31:0] wd,
                      input bit txpop, input bit rxpush, input logic [15:0] rxd, input string tag);
    bit dwr, drd, flush;
    int ts, rs;
    logic [7:0] wa;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    eng_tx_pop = txpop; eng_rx_push = rxpush; eng_rx_data = rxd;
    #2;
    wa = {a[7:2], 2'b00};
    dwr = sel && wr && wa == 8'h60;
    drd = sel && !wr && wa == 8'h60;
    ts = txq.size(); rs = rxq.size();
    flush = sel && wr && wa == 8'h08 && m_en && !wd[0];
    if (sel && !wr) chk(bus_rdata, m_read(a), tag, "rdata");
    chk(32'(tx_ovf_pulse), 32'(dwr && ts == DEPTH), tag, "tx_ovf");
    chk(32'(rx_unf_pulse), 32'(drd && rs == 0), tag, "rx_unf");
    @(posedge clk);
    if (flush) begin
      txq.delete(); rxq.delete();
    end else begin
      if (txpop && ts > 0) void'(txq.pop_front());
      if (dwr && ts < DEPTH) txq.push_back(wd[15:0]);
      if (drd && rs > 0) void'(rxq.pop_front());
      if (rxpush && rs < DEPTH) rxq.push_back(rxd);
    end
    if (sel && wr) begin
      case (wa)
        8'h00: if (!m_en) m_ctrl0 = wd[11:0];
        8'h04: if (!m_en) m_ctrl1 = wd[15:0];
        8'h10: if (!m_en) m_slv = wd[NUM_SS-1:0];
        8'h14: if (!m_en) m_div = wd[15:0];
        8'h08: m_en = wd[0];
        8'h18: if (wd < DEPTH) m_txth = wd;
        8'h1C: if (wd < DEPTH) m_rxth = wd;
        8'hFC: m_dly = wd[7:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk_state(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, 0, 16'h0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(1, 0, a, 32'h0, 0, 0, 16'h0, tag);
  endtask
  task automatic eng(input bit txpop, input bit rxpush, input logic [15:0] d, input string tag);
    step(0, 0, 8'h00, 32'h0, txpop, rxpush, d, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    m_en = 0; m_ctrl0 = '0; m_ctrl1 = '0; m_slv = '0; m_div = '0;
    m_txth = 0; m_rxth = 0; m_dly = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_state("R1");
    rd(8'h28, "R1"); rd(8'h00, "R1"); rd(8'h14, "R1"); rd(8'h20, "R1");
    // control word field packing
    wr(8'h00, 32'hFFFF_FFFF, "R6"); rd(8'h00, "R6");
    wr(8'h00, 32'h0000_03A5, "R6"); rd(8'h00, "R6");
    // configuration while off, then locked while on
    wr(8'h04, 32'hABCD_1234, "R7"); wr(8'h10, 32'h0000_0005, "R7");
    wr(8'h14, 32'h0001_0010, "R7");
    wr(8'h08, 32'h1, "R7");
    wr(8'h00, 32'h0, "R7"); wr(8'h04, 32'h0, "R7");
    wr(8'h10, 32'hF, "R7"); wr(8'h14, 32'h2, "R7");
    rd(8'h00, "R7"); rd(8'h14, "R7"); rd(8'h08, "R7");
    // sample delay writable while on
    wr(8'hFC, 32'h1FF, "R12"); rd(8'hFC, "R12");
    // thresholds: depth probe
    for (int v = 1; v < 9; v++) begin
      wr(8'h18, v, "R9"); rd(8'h18, "R9");
    end
    wr(8'h1C, 32'h100, "R9"); wr(8'h1C, 32'h5, "R9"); wr(8'h1C, 32'h6, "R9"); rd(8'h1C, "R9");
    // transmit path
    wr(8'h60, 32'h0001_BEEF, "R2"); wr(8'h60, 32'h0000_1111, "R2");
    step(1, 1, 8'h60, 32'h2222, 1, 0, 16'h0, "R2");
    rd(8'h20, "R2");
    eng(1, 0, 16'h0, "R2");
    for (int i = 0; i < DEPTH; i++) wr(8'h60, 32'h3000 + i, "R3");
    wr(8'h60, 32'hDEAD, "R3");
    rd(8'h28, "R10");
    step(1, 1, 8'h60, 32'h7777, 1, 0, 16'h0, "R3");
    rd(8'h20, "R3");
    // receive path
    eng(0, 1, 16'hA001, "R4"); eng(0, 1, 16'hA002, "R4");
    step(1, 0, 8'h60, 32'h0, 0, 1, 16'hA003, "R4");
    rd(8'h24, "R4"); rd(8'h60, "R4"); rd(8'h60, "R4");
    rd(8'h60, "R5"); rd(8'h24, "R5");
    for (int i = 0; i < DEPTH + 1; i++) eng(0, 1, 16'hC000 + 16'(i), "R4");
    eng_busy = 1;
    rd(8'h28, "R10");
    step(1, 0, 8'h60, 32'h0, 0, 1, 16'hC0FF, "R4");
    eng_busy = 0;
    rd(8'h28, "R10");
    // flush on disable, engine push in the same cycle discarded
    step(1, 1, 8'h08, 32'h0, 0, 1, 16'hEEEE, "R8");
    rd(8'h20, "R8"); rd(8'h24, "R8"); rd(8'h28, "R8");
    // clearing an already clear enable keeps queued data
    wr(8'h60, 32'h5555, "R8"); wr(8'h08, 32'h0, "R8"); rd(8'h20, "R8");
    // writes accepted again once off
    wr(8'h14, 32'h0000_0042, "R7"); wr(8'h10, 32'h3, "R7"); rd(8'h14, "R7");
    // unmapped
    rd(8'h0C, "R11"); rd(8'h40, "R11"); rd(8'h58, "R11");
    wr(8'h44, 32'hFFFF_FFFF, "R11"); rd(8'h44, "R11");
    rd(8'h03, "R6");
    repeat (2) eng(0, 0, 16'h0, "R1");
    summary();
  end
endmodule